// File: doc/BRIEF.md
# Presettable Programmable Johnson Divider

This block is a five-stage twisted-ring counter that divides its clock by a ratio chosen at run time, from 2 to 10. A 4-bit ratio code picks which stage feeds the ring's serial input back. An even ratio 2N takes the inverted output of stage N. An odd ratio 2N-1 takes the NOR of stages N and N-1, which drops one state from the 2N-state cycle. All five stage outputs are brought out, along with a registered divided clock that follows the selected feedback stage.

A synchronous preset copies five parallel bits into the stages, so the counter can start from any phase. A legality monitor watches the stages in use. When they hold a pattern that cannot occur in the chosen sequence, the whole ring clears on the next edge and counting carries on from zero. This keeps the counter from locking into a parasitic cycle, whether the bad pattern came from a preset or from an upset.

Top module: `jdiv_top`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, every stage and `divclk_o` become 0 at that edge.
- R2: With ratio 10 and no reset or preset, each rising edge shifts stage k into stage k+1 and loads the inverted stage 5 into stage 1, so k edges after reset `stage_o` holds k ones in its low bits (k ≤ 5).
- R3: For an even ratio 2N (N = 1..5), `divclk_o` has a period of 2N clocks and is high for exactly N of them.
- R4: For an odd ratio 2N-1 (N = 2..5), `divclk_o` has a period of 2N-1 clocks and is high for N-1 of them. The state in which all of stages 1..N are one never occurs.
- R5: When `preset_i` is high at an edge and `rst_i` is low, `stage_o` takes `jam_i` at that edge (bit 0 goes to stage 1), overriding counting.
- R6: Reset takes priority over preset: with both high, the stages become 0.
- R7: If the active stages (1..N) hold a pattern that is not in the selected sequence, the next edge without reset or preset clears all stages to 0, and counting resumes from there. The legal patterns are one run of ones followed by one run of zeros, or zeros followed by ones, with all-ones excluded for odd ratios.
- R8: Ratio codes 0, 1 and 11..15 behave exactly like code 10.
- R9: `divclk_o` is registered, and it equals the selected feedback stage (stage N) one edge after that stage is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| rst_i | input | 1 | Synchronous active-high clear |
| preset_i | input | 1 | Synchronous active-high parallel load |
| jam_i | input | 5 | Parallel load value, bit 0 = stage 1 |
| ratio_i | input | 4 | Division ratio code, 2..10 valid |
| stage_o | output | 5 | Stage outputs, bit 0 = stage 1 |
| divclk_o | output | 1 | Divided clock |

## Verification
Every ratio from 2 to 10 is run from reset, and the period and high time of the divided clock are measured. These measurements separate a wrong feedback tap, which changes the period, from wrong odd-ratio gating, which breaks the 2N-1 length or the N-1 high time. Stage values are checked step by step from reset and after a legal preset, which exposes a wrong shift direction or a wrong jam bit order. Illegal presets for an even ratio and an odd ratio confirm that the ring clears after exactly one edge, and the all-ones case shows that the odd legality rule differs from the even one. Reset and preset are applied together to test their priority, and an out-of-range code is checked to give a period of 10.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int STAGES = 5;
  localparam int RW     = 4;
  localparam int MAXR   = 2 * STAGES;

  typedef struct packed {
    logic [RW-1:0] half;  // active stage count N
    logic          odd;
  } ratio_t;

  function automatic ratio_t decode_ratio(input logic [RW-1:0] code);
    ratio_t r;
    logic [RW-1:0] eff;
    if (code < 2 || code > RW'(MAXR)) eff = RW'(MAXR);
    else eff = code;
    r.odd  = eff[0];
    r.half = (eff + 1) >> 1;
    return r;
  endfunction
endpackage

// File: rtl/jdiv_tap_sel.sv
module jdiv_tap_sel
  import jdiv_pkg::*;
#(
  parameter int N_ST = STAGES
) (
  input  logic [N_ST-1:0] q_i,
  input  logic [RW-1:0]   ratio_i,
  output logic            d_o,
  output logic            legal_o,
  output logic [RW-1:0]   tap_o
);
  ratio_t rs;
  logic   hi_tap, lo_tap;
  int     trans;
  logic   all1;

  always_comb begin
    rs     = decode_ratio(ratio_i);
    tap_o  = rs.half - 1'b1;
    hi_tap = q_i[tap_o];
    lo_tap = (rs.half >= 2) ? q_i[rs.half - 2] : 1'b0;
    if (rs.odd) d_o = ~(hi_tap | lo_tap);
    else        d_o = ~hi_tap;
  end

  always_comb begin
    trans = 0;
    all1  = q_i[0];
    for (int i = 1; i < N_ST; i++) begin
      if (i < int'(rs.half)) begin
        if (q_i[i] != q_i[i-1]) trans = trans + 1;
        all1 = all1 & q_i[i];
      end
    end
    legal_o = (trans <= 1) && !(rs.odd && all1);
  end
endmodule

// File: rtl/jdiv_stages.sv
module jdiv_stages
  import jdiv_pkg::*;
#(
  parameter int N_ST = STAGES
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            preset_i,
  input  logic [N_ST-1:0] jam_i,
  input  logic            d_i,
  input  logic            legal_i,
  output logic [N_ST-1:0] q_o,
  output logic [N_ST-1:0] nxt_o
);
  always_comb begin
    if (rst_i)         nxt_o = '0;
    else if (preset_i) nxt_o = jam_i;
    else if (!legal_i) nxt_o = '0;
    else               nxt_o = {q_o[N_ST-2:0], d_i};
  end

  always_ff @(posedge clk_i) q_o <= nxt_o;
endmodule

// File: rtl/jdiv_top.sv
module jdiv_top
  import jdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              preset_i,
  input  logic [STAGES-1:0] jam_i,
  input  logic [RW-1:0]     ratio_i,
  output logic [STAGES-1:0] stage_o,
  output logic              divclk_o
);
  logic              d_w, legal_w;
  logic [RW-1:0]     tap_w;
  logic [STAGES-1:0] nxt_w;

  jdiv_tap_sel #(.N_ST(STAGES)) u_tap (
    .q_i(stage_o), .ratio_i(ratio_i), .d_o(d_w), .legal_o(legal_w), .tap_o(tap_w)
  );

  jdiv_stages #(.N_ST(STAGES)) u_stg (
    .clk_i(clk_i), .rst_i(rst_i), .preset_i(preset_i), .jam_i(jam_i),
    .d_i(d_w), .legal_i(legal_w), .q_o(stage_o), .nxt_o(nxt_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) divclk_o <= 1'b0;
    else       divclk_o <= nxt_w[tap_w];
  end
endmodule

// File: rtl/jdiv_checker.sv
module jdiv_checker
  import jdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              preset_i,
  input logic [STAGES-1:0] jam_i,
  input logic [RW-1:0]     ratio_i,
  input logic [STAGES-1:0] stage_o,
  input logic              divclk_o
);
  logic [STAGES-2:0] edges;
  assign edges = stage_o[STAGES-1:1] ^ stage_o[STAGES-2:0];

  // R1
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (stage_o == '0 && !divclk_o));

  // R5 and R6
  a_r5_preset_loads: assert property (@(posedge clk_i) disable iff (rst_i)
    preset_i |=> stage_o == $past(jam_i));

  // R2 and R7: counting either shifts or clears
  a_r2_shift_or_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    !preset_i |=> (stage_o == '0 || stage_o[STAGES-1:1] == $past(stage_o[STAGES-2:0])));

  // R7: at ratio 10 an illegal pattern never survives a counting edge
  a_r7_no_lock: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i && !preset_i) && $past(ratio_i) == 4'd10) |-> $countones(edges) <= 1);
endmodule

bind jdiv_top jdiv_checker u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .preset_i(preset_i), .jam_i(jam_i),
  .ratio_i(ratio_i), .stage_o(stage_o), .divclk_o(divclk_o)
);

// File: tb/jdiv_top_tb_top.sv
module jdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre = 1'b0;
  logic [4:0] jam = '0;
  logic [3:0] ratio = 4'd10;
  logic [4:0] stage;
  logic       divclk;
  int         n_chk = 0;
  int         n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  jdiv_top dut_i (
    .clk_i(clk), .rst_i(rst), .preset_i(pre), .jam_i(jam),
    .ratio_i(ratio), .stage_o(stage), .divclk_o(divclk)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] r);
    ratio = r; rst = 1'b1; pre = 1'b0; tick(1); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(4'd10);
    check("R1 stages", stage, 0);
    check("R1 divclk", divclk, 0);
  endtask

  task automatic t_seq();
    do_reset(4'd10);
    for (int k = 1; k <= 5; k++) begin
      tick(1);
      check("R2 fill", stage, (1 << k) - 1);
    end
    tick(1);
    check("R2 drain", stage, 5'b11110);
  endtask

  task automatic t_ratio(input logic [3:0] r, input int per, input int hi, input string req);
    int last_rise, rises, highs, per_seen;
    logic prev;
    do_reset(r);
    tick(3 * per);
    prev = divclk; last_rise = -1; rises = 0; highs = 0; per_seen = 0;
    for (int c = 0; c < 4 * per; c++) begin
      tick(1);
      if (divclk && !prev) begin
        if (last_rise >= 0) per_seen = c - last_rise;
        last_rise = c; rises++;
      end
      if (divclk) highs++;
      prev = divclk;
    end
    check({req, " period"}, per_seen, per);
    check({req, " high"}, highs, 4 * hi);
    check("R9 divclk tracks stage", divclk, stage[(per + 1) / 2 - 1]);
  endtask

  task automatic t_odd_skip();
    logic seen;
    seen = 1'b0;
    do_reset(4'd5);
    for (int c = 0; c < 20; c++) begin
      tick(1);
      if (stage[2:0] == 3'b111) seen = 1'b1;
    end
    check("R4 all-ones skipped", seen, 0);
  endtask

  task automatic t_preset();
    do_reset(4'd10);
    tick(2);
    jam = 5'b00011; pre = 1'b1; tick(1); pre = 1'b0;
    check("R5 load", stage, 5'b00011);
    tick(1);
    check("R5 resume", stage, 5'b00111);
    jam = 5'b11000; pre = 1'b1; tick(2); pre = 1'b0;
    check("R5 hold over count", stage, 5'b11000);
  endtask

  task automatic t_priority();
    do_reset(4'd10);
    tick(3);
    jam = 5'b11111; pre = 1'b1; rst = 1'b1; tick(1);
    rst = 1'b0; pre = 1'b0;
    check("R6 reset wins", stage, 0);
  endtask

  task automatic t_illegal();
    do_reset(4'd10);
    jam = 5'b00101; pre = 1'b1; tick(1); pre = 1'b0;
    check("R7 illegal loaded", stage, 5'b00101);
    tick(1);
    check("R7 cleared", stage, 0);
    tick(1);
    check("R7 resumed", stage, 5'b00001);
    do_reset(4'd5);
    jam = 5'b00111; pre = 1'b1; tick(1); pre = 1'b0;
    tick(1);
    check("R7 odd all-ones cleared", stage, 0);
    do_reset(4'd4);
    jam = 5'b10100; pre = 1'b1; tick(1); pre = 1'b0;
    tick(1);
    check("R7 inactive stages ignored", stage, 5'b01001);
  endtask

  initial begin
    t_reset();
    t_seq();
    for (int n = 1; n <= 5; n++)
      t_ratio(4'(2 * n), 2 * n, n, "R3");
    for (int n = 2; n <= 5; n++)
      t_ratio(4'(2 * n - 1), 2 * n - 1, n - 1, "R4");
    t_odd_skip();
    t_ratio(4'd0, 10, 5, "R8 code0");
    t_ratio(4'd13, 10, 5, "R8 code13");
    t_preset();
    t_priority();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule